// File: doc/BRIEF.md
# Segmented Effective Address Calculator

This unit works out the 30-bit effective address of an instruction for a 36-bit word machine. The address space is split into sections. Each address is a 12-bit section number above an 18-bit word number. A pulse on `start` loads an instruction word and the section the program counter is in. The unit then steps through indexing and any chain of indirect words. It reads index registers through a combinational read port. It fetches each indirect word through a memory read port that uses a request/acknowledge handshake.

When the program-counter section is zero, the unit follows the original flat 18-bit rules. Otherwise, at every step it decides whether the arithmetic is local or global. A local result takes its section from the word that held the address, so the default section moves with each indirect word fetched. A global result carries its own section. On completion the unit raises `done` for one cycle. It then holds the address, a global flag and a flag showing that the target is one of the sixteen hardware accumulators.

Bit numbering in this document runs from 0 for the most significant bit of a 36-bit word to 35 for the least significant. Doc bit k is vector index 35-k.

Top module: `seg_ea_unit`

## Requirements
- R1: Instruction fields are I at bit 13, X at bits 14-17 and Y at bits 18-35. X equal to 0 means no indexing. With I=0 and X=0 the result is local, with word Y in the PC section. `done` rises 2 clock edges after the edge that samples `start`.
- R2: With PC section 0, every step uses 18-bit arithmetic only. The result is Y plus the right half of the index register, modulo 2^18, in section 0, and it is always local. In this mode every indirect word is read with the fields at bits 13-35, whatever the value of its bit 0.
- R3: In a non-zero PC section, an index register whose left half (bits 0-17) is zero or negative (bit 0 set) adds its right half to Y modulo 2^18. This gives a local address in the default section.
- R4: In a non-zero PC section, an index register whose left half is positive and non-zero gives a global result. The result is its low 30 bits plus Y sign-extended from bit 18, modulo 2^30, and a carry may enter the section.
- R5: An indirect word with bit 0 set holds I at bit 13, X at bits 14-17 and Y at bits 18-35. A local address it produces takes its section from the address that word was fetched from.
- R6: An indirect word with bit 0 clear holds I at bit 1, X at bits 2-5 and a 30-bit Y at bits 6-35. Its result is always global. When X is non-zero, the full low 30 bits of the index register are added, whatever its left half holds.
- R7: Each indirect word is decoded by its own bit 0, whatever the format of the word before it. A chain of several indirect words is followed until I=0.
- R8: `ea_is_ac` is 1 when the result is local with word 0-15. It is also 1 when the result is global in section 1 with word 0-15. A global word 0-15 in any other section gives 0.
- R9: Each indirect word costs one memory request. `mem_req` stays high with `mem_addr` stable until `mem_ack`, and it drops in the cycle after the acknowledge. The request address is the full 30-bit address computed at that step.
- R10: `done` is high for exactly one cycle, and the results stay unchanged until the next calculation. A `start` that arrives while a calculation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation; sampled only when idle |
| instr | input | 36 | Instruction word |
| pc_sect | input | 12 | Section of the program counter |
| xr_sel | output | 4 | Index register number being read |
| xr_data | input | 36 | Contents of the selected index register (combinational) |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 30 | Address of the indirect word |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 36 | Indirect word read from memory |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 30 | Effective address: section in [29:18], word in [17:0] |
| ea_global | output | 1 | 1 when the result is a global address |
| ea_is_ac | output | 1 | 1 when the result targets a hardware accumulator |

## Verification
With no indirection, the result and `done` are due on the second clock edge after the edge that samples `start`. The bench counts falling edges from that sample and checks for exactly 2. Each indirect level adds the cycles spent waiting in the request, plus one calculation cycle. For that reason the chained cases wait for `done` and then check the result together with the number of fetches made. All outputs are read on the falling edge after `done` rises. The bench also checks that `done` is low one cycle later and that the results are still unchanged.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  localparam int WORD_W = 36;
  localparam int HALF_W = 18;
  localparam int SECT_W = 12;
  localparam int ADDR_W = SECT_W + HALF_W;
  localparam int XSEL_W = 4;
  // vector index of doc bit k is WORD_W-1-k
  localparam int IF_I_POS = WORD_W - 1 - 13;
  localparam int IF_X_LSB = WORD_W - 1 - 17;
  localparam int EF_I_POS = WORD_W - 1 - 1;
  localparam int EF_X_LSB = WORD_W - 1 - 5;
  localparam int FMT_POS  = WORD_W - 1;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic              ind;
    logic [XSEL_W-1:0] xsel;
    addr_t             y;
    logic              efmt;
  } ea_step_t;

  function automatic logic [HALF_W-1:0] add_local(input logic [HALF_W-1:0] a,
                                                  input logic [HALF_W-1:0] b);
    return a + b;
  endfunction

  function automatic addr_t sext_half(input logic [HALF_W-1:0] y);
    return {{(ADDR_W-HALF_W){y[HALF_W-1]}}, y};
  endfunction

  function automatic addr_t add_global(input addr_t a, input addr_t b);
    return a + b;
  endfunction

  function automatic logic left_is_global(input logic [WORD_W-1:0] r);
    return !r[WORD_W-1] && (r[WORD_W-1:HALF_W] != '0);
  endfunction
endpackage

// File: rtl/seg_ea_iw_decode.sv
module seg_ea_iw_decode
  import seg_ea_pkg::*;
(
  input  logic              ext_mode,
  input  logic [WORD_W-1:0] word,
  output ea_step_t          step
);
  logic use_ext;
  assign use_ext = ext_mode && !word[FMT_POS];

  always_comb begin
    if (use_ext) begin
      step.ind  = word[EF_I_POS];
      step.xsel = word[EF_X_LSB +: XSEL_W];
      step.y    = word[ADDR_W-1:0];
      step.efmt = 1'b1;
    end else begin
      step.ind  = word[IF_I_POS];
      step.xsel = word[IF_X_LSB +: XSEL_W];
      step.y    = {{SECT_W{1'b0}}, word[HALF_W-1:0]};
      step.efmt = 1'b0;
    end
  end
endmodule

// File: rtl/seg_ea_idx_unit.sv
module seg_ea_idx_unit
  import seg_ea_pkg::*;
(
  input  logic              ext_mode,
  input  ea_step_t          step,
  input  logic [SECT_W-1:0] def_sect,
  input  logic [WORD_W-1:0] xr_data,
  output addr_t             addr,
  output logic              is_global
);
  logic              use_x;
  logic [HALF_W-1:0] y_half;
  logic [HALF_W-1:0] x_right;
  addr_t             x_full;
  logic              path_flat, path_efmt, path_xglob;

  assign use_x     = step.xsel != '0;
  assign y_half    = step.y[HALF_W-1:0];
  assign x_right   = use_x ? xr_data[HALF_W-1:0] : '0;
  assign x_full    = use_x ? xr_data[ADDR_W-1:0] : '0;
  assign path_flat  = !ext_mode;
  assign path_efmt  = ext_mode && step.efmt;
  assign path_xglob = ext_mode && !step.efmt && use_x && left_is_global(xr_data);

  always_comb begin
    if (path_flat) begin
      addr      = {{SECT_W{1'b0}}, add_local(y_half, x_right)};
      is_global = 1'b0;
    end else if (path_efmt) begin
      addr      = add_global(step.y, x_full);
      is_global = 1'b1;
    end else if (path_xglob) begin
      addr      = add_global(xr_data[ADDR_W-1:0], sext_half(y_half));
      is_global = 1'b1;
    end else begin
      addr      = {def_sect, add_local(y_half, x_right)};
      is_global = 1'b0;
    end
  end
endmodule

// File: rtl/seg_ea_ac_detect.sv
module seg_ea_ac_detect
  import seg_ea_pkg::*;
#(
  parameter int AC_WORDS   = 16,
  parameter int AC_GL_SECT = 1
) (
  input  addr_t addr,
  input  logic  is_global,
  output logic  is_ac
);
  logic low_word, sect_ok;
  assign low_word = addr[HALF_W-1:0] < HALF_W'(AC_WORDS);
  assign sect_ok  = !is_global || (addr[ADDR_W-1:HALF_W] == SECT_W'(AC_GL_SECT));
  assign is_ac    = low_word && sect_ok;
endmodule

// File: rtl/seg_ea_unit.sv
module seg_ea_unit
  import seg_ea_pkg::*;
#(
  parameter int AC_WORDS   = 16,
  parameter int AC_GL_SECT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [SECT_W-1:0] pc_sect,
  output logic [XSEL_W-1:0] xr_sel,
  input  logic [WORD_W-1:0] xr_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic              ea_global,
  output logic              ea_is_ac
);
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_FETCH} st_t;

  st_t               state;
  logic              ext_r;
  ea_step_t          step_r;
  logic [SECT_W-1:0] def_sect_r;
  addr_t             fetch_addr_r;
  addr_t             ea_r;
  logic              glob_r, isac_r, done_r;

  ea_step_t instr_step, iw_step;
  addr_t    calc_addr;
  logic     calc_global, calc_is_ac;

  // named events for the checks below
  logic accept_start, iw_taken, finish_step, chain_step;
  assign accept_start = (state == ST_IDLE) && start;
  assign iw_taken     = (state == ST_FETCH) && mem_ack;
  assign finish_step  = (state == ST_CALC) && !step_r.ind;
  assign chain_step   = (state == ST_CALC) && step_r.ind;

  seg_ea_iw_decode u_instr_dec (
    .ext_mode (1'b0),
    .word     (instr),
    .step     (instr_step)
  );

  seg_ea_iw_decode u_iw_dec (
    .ext_mode (ext_r),
    .word     (mem_rdata),
    .step     (iw_step)
  );

  seg_ea_idx_unit u_idx (
    .ext_mode  (ext_r),
    .step      (step_r),
    .def_sect  (def_sect_r),
    .xr_data   (xr_data),
    .addr      (calc_addr),
    .is_global (calc_global)
  );

  seg_ea_ac_detect #(.AC_WORDS(AC_WORDS), .AC_GL_SECT(AC_GL_SECT)) u_ac (
    .addr      (calc_addr),
    .is_global (calc_global),
    .is_ac     (calc_is_ac)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ext_r        <= 1'b0;
      step_r       <= '0;
      def_sect_r   <= '0;
      fetch_addr_r <= '0;
      ea_r         <= '0;
      glob_r       <= 1'b0;
      isac_r       <= 1'b0;
      done_r       <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept_start) begin
          ext_r      <= pc_sect != '0;
          step_r     <= instr_step;
          def_sect_r <= pc_sect;
          state      <= ST_CALC;
        end
        ST_CALC: begin
          if (chain_step) begin
            fetch_addr_r <= calc_addr;
            state        <= ST_FETCH;
          end else begin
            ea_r   <= calc_addr;
            glob_r <= calc_global;
            isac_r <= calc_is_ac;
            done_r <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_FETCH: if (iw_taken) begin
          step_r     <= iw_step;
          def_sect_r <= fetch_addr_r[ADDR_W-1:HALF_W];
          state      <= ST_CALC;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign xr_sel    = step_r.xsel;
  assign mem_req   = state == ST_FETCH;
  assign mem_addr  = fetch_addr_r;
  assign done      = done_r;
  assign ea        = ea_r;
  assign ea_global = glob_r;
  assign ea_is_ac  = isac_r;

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r9_req_release: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  a_r2_flat_local: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ext_r |-> !ea_global && (ea[ADDR_W-1:HALF_W] == '0));

  a_r8_ac_low_word: assert property (@(posedge clk) disable iff (!rst_n)
    done && ea_is_ac |-> ea[HALF_W-1:0] < HALF_W'(AC_WORDS));

  a_r6_efmt_global: assert property (@(posedge clk) disable iff (!rst_n)
    finish_step && step_r.efmt |=> done && ea_global);

  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && (state == ST_FETCH) |=> state != ST_IDLE);
endmodule

// File: tb/seg_ea_unit_tb.sv
module seg_ea_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [35:0] instr = '0;
  logic [11:0] pc_sect = '0;
  logic [3:0]  xr_sel;
  logic [35:0] xr_data;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [35:0] mem_rdata = '0;
  logic        done;
  logic [29:0] ea;
  logic        ea_global, ea_is_ac;

  int tests = 0;
  int fails = 0;
  int lat = 0;
  int wait_cnt = 0;
  int fetches = 0;
  int hold_viol = 0;

  logic [35:0] xregs [16];
  logic [35:0] mem [logic [29:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_ea_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_sect(pc_sect),
    .xr_sel(xr_sel), .xr_data(xr_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .ea(ea),
    .ea_global(ea_global), .ea_is_ac(ea_is_ac)
  );

  assign xr_data = xregs[xr_sel];

  // memory model: acknowledge after lat waiting edges
  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 36'h0;
        fetches   <= fetches + 1;
        wait_cnt  <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  // R9 monitor: request held with stable address until acknowledged
  logic        p_req = 1'b0, p_ack = 1'b0;
  logic [29:0] p_addr = '0;
  always @(negedge clk) begin
    if (p_req && !p_ack && (!mem_req || mem_addr != p_addr)) hold_viol <= hold_viol + 1;
    p_req  <= mem_req;
    p_ack  <= mem_ack;
    p_addr <= mem_addr;
  end

  function automatic logic [35:0] mk_ins(input logic i, input logic [3:0] x, input logic [17:0] y);
    return {13'b0, i, x, y};
  endfunction
  function automatic logic [35:0] mk_ifw(input logic i, input logic [3:0] x, input logic [17:0] y);
    return {1'b1, 12'b0, i, x, y};
  endfunction
  function automatic logic [35:0] mk_efw(input logic i, input logic [3:0] x, input logic [29:0] y);
    return {1'b0, i, x, y};
  endfunction
  function automatic logic [29:0] ad(input logic [11:0] s, input logic [17:0] w);
    return {s, w};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int k = 0; k < 16; k++) xregs[k] = '0;
    mem.delete();
    lat = 0;
  endtask

  // issue one calculation, return falling edges until done
  task automatic run_ea(input logic [35:0] ins, input logic [11:0] ps, output int cyc);
    @(negedge clk);
    instr = ins; pc_sect = ps; start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end while (!done && cyc < 200);
  endtask

  task automatic t_reset();
    chk("R10", "reset done", done, 0);
    chk("R9", "reset mem_req", mem_req, 0);
    chk("R10", "reset ea", ea, 0);
  endtask

  task automatic t_direct(); // R1
    int c;
    clear_all();
    run_ea(mk_ins(0, 0, 18'o1000), 12'd3, c);
    chk("R1", "direct ea", ea, ad(3, 18'o1000));
    chk("R1", "direct global", ea_global, 0);
    chk("R1", "direct is_ac", ea_is_ac, 0);
    chk("R1", "direct latency", c, 2);
  endtask

  task automatic t_flat(); // R2
    int c;
    clear_all();
    xregs[2] = {18'h00005, 18'h3FFFF};
    run_ea(mk_ins(0, 2, 18'h5), 12'd0, c);
    chk("R2", "flat wrap ea", ea, ad(0, 18'h4));
    chk("R2", "flat global", ea_global, 0);
    chk("R8", "flat local ac", ea_is_ac, 1);
    mem[ad(0, 18'h100)] = {1'b0, 1'b1, 4'b0, 7'h55, 5'b0, 18'h123};
    run_ea(mk_ins(1, 0, 18'h100), 12'd0, c);
    chk("R2", "flat indirect ea", ea, ad(0, 18'h123));
    chk("R2", "flat indirect global", ea_global, 0);
  endtask

  task automatic t_local_idx(); // R3
    int c;
    clear_all();
    xregs[3] = {18'h3FFF0, 18'h00010};
    run_ea(mk_ins(0, 3, 18'h3FFF8), 12'd5, c);
    chk("R3", "neg left ea", ea, ad(5, 18'h8));
    chk("R3", "neg left global", ea_global, 0);
    chk("R8", "local ac", ea_is_ac, 1);
    xregs[4] = {18'h0, 18'h100};
    run_ea(mk_ins(0, 4, 18'h20), 12'd5, c);
    chk("R3", "zero left ea", ea, ad(5, 18'h120));
  endtask

  task automatic t_global_idx(); // R4
    int c;
    clear_all();
    xregs[6] = {6'b0, 12'h007, 18'h00100};
    run_ea(mk_ins(0, 6, 18'h3FFFF), 12'd5, c);
    chk("R4", "neg offset ea", ea, ad(7, 18'h000FF));
    chk("R4", "neg offset global", ea_global, 1);
    xregs[7] = {6'b0, 12'h001, 18'h3FFFE};
    run_ea(mk_ins(0, 7, 18'h5), 12'd5, c);
    chk("R4", "section carry ea", ea, ad(2, 18'h3));
    chk("R8", "global sect2 low word not ac", ea_is_ac, 0);
    xregs[8] = {6'b0, 12'h001, 18'h00001};
    run_ea(mk_ins(0, 8, 18'h2), 12'd5, c);
    chk("R8", "global sect1 ea", ea, ad(1, 18'h3));
    chk("R8", "global sect1 ac", ea_is_ac, 1);
  endtask

  task automatic t_ifiw(); // R5
    int c, f0;
    clear_all();
    lat = 1;
    xregs[6] = {6'b0, 12'h007, 18'h00100};
    mem[ad(7, 18'h100)] = mk_ifw(0, 0, 18'h00A);
    f0 = fetches;
    run_ea(mk_ins(1, 6, 18'h0), 12'd2, c);
    chk("R5", "ifiw section follows word", ea, ad(7, 18'h00A));
    chk("R5", "ifiw global", ea_global, 0);
    chk("R8", "ifiw local ac", ea_is_ac, 1);
    chk("R9", "ifiw fetch count", fetches - f0, 1);
  endtask

  task automatic t_efiw(); // R6
    int c;
    clear_all();
    xregs[4] = {18'h0, 18'h100};
    mem[ad(2, 18'h400)] = mk_efw(0, 4, ad(12'h010, 18'h3FFF0));
    run_ea(mk_ins(1, 0, 18'h400), 12'd2, c);
    chk("R6", "efiw full add ea", ea, ad(12'h011, 18'h000F0));
    chk("R6", "efiw global", ea_global, 1);
  endtask

  task automatic t_chain(); // R7
    int c, f0;
    clear_all();
    lat = 2;
    xregs[3] = {18'h3FFF0, 18'h00010};
    mem[ad(3, 18'h200)] = mk_efw(1, 0, ad(9, 18'h300));
    mem[ad(9, 18'h300)] = mk_ifw(1, 0, 18'h40);
    mem[ad(9, 18'h040)] = mk_ifw(0, 3, 18'h5);
    f0 = fetches;
    run_ea(mk_ins(1, 0, 18'h200), 12'd3, c);
    chk("R7", "chain ea", ea, ad(9, 18'h15));
    chk("R7", "chain global", ea_global, 0);
    chk("R9", "chain fetch count", fetches - f0, 3);
  endtask

  task automatic t_busy(); // R10
    int c;
    logic [29:0] held;
    clear_all();
    lat = 4;
    mem[ad(2, 18'h400)] = mk_ifw(0, 0, 18'h0AA);
    @(negedge clk);
    instr = mk_ins(1, 0, 18'h400); pc_sect = 12'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    instr = mk_ins(0, 0, 18'h777); pc_sect = 12'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    c = 0;
    while (!done && c < 200) begin @(negedge clk); c++; end
    chk("R10", "busy start ignored ea", ea, ad(2, 18'h0AA));
    held = ea;
    @(negedge clk);
    chk("R10", "done single cycle", done, 0);
    chk("R10", "result held", ea, held);
    c = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (done) c++; end
    chk("R10", "no queued second run", c, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_direct();
    t_flat();
    t_local_idx();
    t_global_idx();
    t_ifiw();
    t_efiw();
    t_chain();
    t_busy();
    chk("R9", "request hold violations", hold_viol, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule